// File: doc/BRIEF.md
# Dual-Port Debug Control Register

This block holds the 32-bit control word of a debug unit. Two agents reach it. Privileged software on the core uses one port. An external debugger uses a second port, whose write strobe has already been brought into the core clock domain. Each field has its own access rule on each port. The software port owns the global debug enable. The debugger port owns the halt/monitor mode select and seven exception trap enables. A write from a port to a field that port does not own is dropped without any error.

Two reset inputs act on separate groups of fields. The system reset clears only the global enable. The test-logic reset clears only the mode select and the trap enables. The block drives decoded outputs to the rest of the debug unit: the global enable, the mode select, and the trap enables. The trap enables are forced low while debugging is disabled.

Top module: `dbg_ctrl_reg`

## Requirements
- R1: Bit 31 of the word is the global debug enable. A software write loads it from the software write data at the clock edge that samples the strobe, and `dbg_enable_o` follows it (1 = debug enabled).
- R2: Bit 31 in a debugger-port write has no effect on the global enable.
- R3: Bit 30 is the mode select, written only through the debugger port. `halt_mode_o` follows it (1 = halt mode, 0 = monitor mode).
- R4: The trap enables are written through the debugger port at bits 23 (FIQ), 22 (IRQ), 20 (data abort), 19 (prefetch abort), 18 (software interrupt), 17 (undefined instruction) and 16 (reset). Writing 1 sets a trap enable and writing 0 clears it.
- R5: Software writes to bit 30 and to the trap bits have no effect.
- R6: Bits 29:24 and bit 21 always read as 0 on both ports, whatever value was written to them.
- R7: Both read ports always return the same complete current word.
- R8: While the system reset is high at a clock edge, the global enable clears to 0. The mode select and the trap enables keep their values unless the debugger port writes them in that cycle.
- R9: While the test-logic reset is high at a clock edge, the mode select and all trap enables clear to 0. The global enable keeps its value unless software writes it in that cycle.
- R10: With both resets high, the whole word clears to 0.
- R11: When both ports write in the same cycle, each port updates its own fields and neither disturbs the other.
- R12: `trap_en_o` is {FIQ, IRQ, data abort, prefetch abort, software interrupt, undefined, reset} from bit 6 down to bit 0. It equals the stored trap enables while the global enable is 1 and is all zeros while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| sys_rst | input | 1 | Synchronous system reset, active high |
| tap_rst | input | 1 | Synchronous test-logic reset, active high |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Word seen by software |
| jt_wr_en | input | 1 | Debugger write strobe, already synchronized |
| jt_wdata | input | 32 | Debugger write data |
| jt_rdata | output | 32 | Word seen by the debugger |
| dbg_enable_o | output | 1 | Global debug enable |
| halt_mode_o | output | 1 | 1 = halt mode, 0 = monitor mode |
| trap_en_o | output | 7 | Trap enables, gated by the global enable |

## Verification
On every cycle the assertions check four things. First, a software write lands in the global enable and a debugger write lands in the mode bit one edge later. Second, each field stays put when no write is made by its owning port. Third, each reset clears its own group of fields. Fourth, no trap output is high while debugging is disabled. Some behaviour only the bench's scenarios can show: exact word values after mixed and simultaneous writes, reserved bits reading zero after writes of all ones, and fields surviving the reset that is not theirs.

// File: rtl/dbgreg_pkg.sv
package dbgreg_pkg;

    localparam int REG_W  = 32;
    localparam int GE_BIT = 31;
    localparam int HM_BIT = 30;
    localparam int TRAP_N = 7;

    // Bit position of trap k; k = 0 is the reset trap, k = 6 the FIQ trap.
    function automatic int trap_pos(input int k);
        return (k < 5) ? (16 + k) : (17 + k);
    endfunction

    function automatic logic [REG_W-1:0] calc_trap_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int k = 0; k < TRAP_N; k++) m[trap_pos(k)] = 1'b1;
        return m;
    endfunction

    localparam logic [REG_W-1:0] TRAP_MASK = calc_trap_mask();

    typedef struct packed {
        logic              ge;
        logic              hm;
        logic [TRAP_N-1:0] trap;
    } dbg_state_t;

endpackage

// File: rtl/dbgreg_next.sv
module dbgreg_next
    import dbgreg_pkg::*;
(
    input  dbg_state_t       state_q,
    input  logic             sys_rst,
    input  logic             tap_rst,
    input  logic             sw_wr_en,
    input  logic [REG_W-1:0] sw_wdata,
    input  logic             jt_wr_en,
    input  logic [REG_W-1:0] jt_wdata,
    output dbg_state_t       state_d
);

    // Bits a port may not write are dropped here.
    logic unused_sw_bits;
    logic unused_jt_bits;
    assign unused_sw_bits = ^(sw_wdata & ~(REG_W'(1) << GE_BIT));
    assign unused_jt_bits = ^(jt_wdata & ~(TRAP_MASK | (REG_W'(1) << HM_BIT)));

    always_comb begin
        state_d = state_q;
        // Software-owned field.
        if (sys_rst)
            state_d.ge = 1'b0;
        else if (sw_wr_en)
            state_d.ge = sw_wdata[GE_BIT];
        // Debugger-owned fields.
        if (tap_rst) begin
            state_d.hm   = 1'b0;
            state_d.trap = '0;
        end else if (jt_wr_en) begin
            state_d.hm = jt_wdata[HM_BIT];
            for (int k = 0; k < TRAP_N; k++)
                state_d.trap[k] = jt_wdata[trap_pos(k)];
        end
    end

endmodule

// File: rtl/dbgreg_pack.sv
module dbgreg_pack
    import dbgreg_pkg::*;
(
    input  dbg_state_t       state,
    output logic [REG_W-1:0] word
);

    logic [REG_W-1:0] trap_bits;

    for (genvar k = 0; k < REG_W; k++) begin : g_bit
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int t = 0; t < TRAP_N; t++)
                if (trap_pos(t) == k) hit = state.trap[t];
        end
        assign trap_bits[k] = hit;
    end

    always_comb begin
        word         = trap_bits & TRAP_MASK;
        word[GE_BIT] = state.ge;
        word[HM_BIT] = state.hm;
    end

endmodule

// File: rtl/dbgreg_trap_gate.sv
module dbgreg_trap_gate #(
    parameter int N = 7
) (
    input  logic         enable,
    input  logic [N-1:0] trap_in,
    output logic [N-1:0] trap_out
);

    for (genvar i = 0; i < N; i++) begin : g_gate
        assign trap_out[i] = enable & trap_in[i];
    end

endmodule

// File: rtl/dbg_ctrl_reg.sv
module dbg_ctrl_reg
    import dbgreg_pkg::*;
(
    input  logic              clk,
    input  logic              sys_rst,
    input  logic              tap_rst,
    input  logic              sw_wr_en,
    input  logic [31:0]       sw_wdata,
    output logic [31:0]       sw_rdata,
    input  logic              jt_wr_en,
    input  logic [31:0]       jt_wdata,
    output logic [31:0]       jt_rdata,
    output logic              dbg_enable_o,
    output logic              halt_mode_o,
    output logic [6:0]        trap_en_o
);

    dbg_state_t       state_d;
    dbg_state_t       state_q;
    logic [REG_W-1:0] word;

    dbgreg_next u_next (
        .state_q  (state_q),
        .sys_rst  (sys_rst),
        .tap_rst  (tap_rst),
        .sw_wr_en (sw_wr_en),
        .sw_wdata (sw_wdata),
        .jt_wr_en (jt_wr_en),
        .jt_wdata (jt_wdata),
        .state_d  (state_d)
    );

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    dbgreg_pack u_pack (
        .state (state_q),
        .word  (word)
    );

    dbgreg_trap_gate #(.N(TRAP_N)) u_gate (
        .enable   (state_q.ge),
        .trap_in  (state_q.trap),
        .trap_out (trap_en_o)
    );

    assign sw_rdata     = word;
    assign jt_rdata     = word;
    assign dbg_enable_o = state_q.ge;
    assign halt_mode_o  = state_q.hm;

    // ---------------- assertions ----------------
    a_r1_ge_follows_sw: assert property (@(posedge clk) disable iff (sys_rst || tap_rst)
        sw_wr_en |=> (dbg_enable_o == $past(sw_wdata[GE_BIT])));

    a_r2_ge_holds: assert property (@(posedge clk) disable iff (sys_rst || tap_rst)
        !sw_wr_en |=> $stable(dbg_enable_o));

    a_r3_mode_follows_jt: assert property (@(posedge clk) disable iff (sys_rst || tap_rst)
        jt_wr_en |=> (halt_mode_o == $past(jt_wdata[HM_BIT])));

    a_r5_jt_fields_hold: assert property (@(posedge clk) disable iff (sys_rst || tap_rst)
        !jt_wr_en |=> ($stable(halt_mode_o) && $stable(jt_rdata & TRAP_MASK)));

    a_r8_sys_clears_ge: assert property (@(posedge clk)
        sys_rst |=> !dbg_enable_o);

    a_r9_tap_clears_fields: assert property (@(posedge clk)
        tap_rst |=> (!halt_mode_o && ((sw_rdata & TRAP_MASK) == '0)));

    a_r12_gated_traps: assert property (@(posedge clk) disable iff (sys_rst || tap_rst)
        !dbg_enable_o |-> (trap_en_o == '0));

endmodule

// File: tb/sim_dbg_ctrl_reg.sv
`timescale 1ns/1ps
module sim_dbg_ctrl_reg;

    logic        clk = 1'b0;
    logic        sys_rst, tap_rst, sw_wr_en, jt_wr_en;
    logic [31:0] sw_wdata, jt_wdata, sw_rdata, jt_rdata;
    logic        dbg_enable_o, halt_mode_o;
    logic [6:0]  trap_en_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dbg_ctrl_reg u0 (
        .clk(clk), .sys_rst(sys_rst), .tap_rst(tap_rst),
        .sw_wr_en(sw_wr_en), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .jt_wr_en(jt_wr_en), .jt_wdata(jt_wdata), .jt_rdata(jt_rdata),
        .dbg_enable_o(dbg_enable_o), .halt_mode_o(halt_mode_o), .trap_en_o(trap_en_o)
    );

    typedef struct packed {
        logic        sw_we;
        logic [31:0] sw_wd;
        logic        jt_we;
        logic [31:0] jt_wd;
        logic        sys;
        logic        tap;
        logic [31:0] expect_w;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0,         1'b0, 1'b0, 32'h8000_0000, 8'd5},  // R5 R6 R1
        '{1'b0, 32'h0,         1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'hC0DF_0000, 8'd6},  // R6 R4
        '{1'b0, 32'h0,         1'b1, 32'h0,         1'b0, 1'b0, 32'h8000_0000, 8'd2},  // R2
        '{1'b0, 32'h0,         1'b1, 32'h40A5_0000, 1'b0, 1'b0, 32'hC085_0000, 8'd4},  // R4 R3
        '{1'b1, 32'h0,         1'b0, 32'h0,         1'b0, 1'b0, 32'h4085_0000, 8'd1},  // R1
        '{1'b1, 32'h8000_0000, 1'b1, 32'h0042_0000, 1'b0, 1'b0, 32'h8042_0000, 8'd11}, // R11
        '{1'b0, 32'h0,         1'b0, 32'h0,         1'b1, 1'b0, 32'h0042_0000, 8'd8},  // R8
        '{1'b1, 32'h8000_0000, 1'b0, 32'h0,         1'b0, 1'b0, 32'h8042_0000, 8'd1},  // R1
        '{1'b0, 32'h0,         1'b0, 32'h0,         1'b0, 1'b1, 32'h8000_0000, 8'd9},  // R9
        '{1'b0, 32'h0,         1'b1, 32'h7FFF_FFFF, 1'b0, 1'b0, 32'hC0DF_0000, 8'd4},  // R4
        '{1'b0, 32'h0,         1'b0, 32'h0,         1'b1, 1'b1, 32'h0000_0000, 8'd10}, // R10
        '{1'b0, 32'h0,         1'b1, 32'h4001_0000, 1'b1, 1'b0, 32'h4001_0000, 8'd8},  // R8
        '{1'b1, 32'h8000_0000, 1'b0, 32'h0,         1'b0, 1'b1, 32'h8000_0000, 8'd9}   // R9
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Checks every output against an expected word; trap output derived per R12.
    task automatic check_word(input string req, input logic [31:0] w);
        logic [6:0] tr;
        tr = w[31] ? {w[23], w[22], w[20], w[19], w[18], w[17], w[16]} : 7'd0;
        check(req, "sw_rdata", sw_rdata, w);
        check("R7", "jt_rdata", jt_rdata, w);
        check(req, "dbg_enable_o", {31'd0, dbg_enable_o}, {31'd0, w[31]});
        check(req, "halt_mode_o", {31'd0, halt_mode_o}, {31'd0, w[30]});
        check("R12", "trap_en_o", {25'd0, trap_en_o}, {25'd0, tr});
    endtask

    task automatic drive(input vec_t v);
        sw_wr_en = v.sw_we; sw_wdata = v.sw_wd;
        jt_wr_en = v.jt_we; jt_wdata = v.jt_wd;
        sys_rst  = v.sys;   tap_rst  = v.tap;
    endtask

    task automatic idle();
        drive('{1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 8'd0});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle();
        sys_rst = 1'b1; tap_rst = 1'b1;
        repeat (2) @(negedge clk);
        idle();
        check_word("R10", 32'h0);   // reset state

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            idle();
            check_word($sformatf("R%0d", VECS[i].req), VECS[i].expect_w);
        end

        // R12 gating: traps stored, enable off -> outputs low, then enable on.
        drive('{1'b1, 32'h0, 1'b1, 32'h00DF_0000, 1'b0, 1'b0, 32'h0, 8'd0});
        @(negedge clk);
        idle();
        check("R12", "trap_en_o while disabled", {25'd0, trap_en_o}, 32'd0);
        check("R4", "stored traps", sw_rdata, 32'h00DF_0000);
        drive('{1'b1, 32'h8000_0000, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 8'd0});
        @(negedge clk);
        idle();
        check("R12", "trap_en_o while enabled", {25'd0, trap_en_o}, 32'h7F);

        // Idle cycles leave the word unchanged (R2, R5).
        repeat (3) @(negedge clk);
        check_word("R5", 32'h80DF_0000);

        // R6: reserved-only writes from both ports.
        drive('{1'b1, 32'h3F20_0000, 1'b1, 32'h3F20_0000, 1'b0, 1'b0, 32'h0, 8'd0});
        @(negedge clk);
        idle();
        check_word("R6", 32'h0000_0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule